// File: doc/BRIEF.md
# PCIe Root-Port Interrupt Collector

This block gathers every interrupt that a PCIe root port receives and reduces it to one interrupt line for the CPU. Message-signalled interrupts arrive on an inbound write port as an address and a data word. Each of the parameterised MSI groups (eight by default) owns a 64-bit capture address. A write that lands on an open group's address sets one of the group's 32 pending bits, and the low data bits select which one. Legacy INTx interrupts arrive as assert and deassert messages for four virtual lines. Each line has a level-style status bit in the top-level status word.

Software programs the capture addresses, the per-vector enables, the per-group gates and the top-level enables through a simple register write port. It reads state back through a read port with one cycle of latency. Software acknowledges interrupts by writing ones to the pending and status registers. Each group's enabled pending bits collapse into one summary bit of the top-level status word. The registered interrupt output is raised whenever an enabled status bit is set.

Top module: `irq_collector`

## Requirements
- R1: While reset is high and in the first cycle after it, `irq` and `capture_err` are 0. After reset, every capture address, pending bit, vector enable, group gate and top-level enable reads 0.
- R2: An inbound write (`in_valid`=1) sets pending bit `in_data[4:0]` of group g when `in_addr` equals g's {high word, low word} and bit g of the gate register (0x190) is 1. Data bits above bit 4 are ignored.
- R3: Writing to a group's pending register (0xC04 + 0x10·g) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: When a capture and a software clear hit the same pending bit in the same cycle, the bit ends up set.
- R5: Status word bit 8+g (read at 0x184) is 1 exactly when group g has a pending bit whose vector enable bit (0xC08 + 0x10·g) is also 1.
- R6: An INTx assert message for line n sets status bit 24+n. While line n is asserted, writing 1 to that bit has no effect. After a deassert message, the bit stays set until software writes 1 to it.
- R7: `irq` equals the OR of (status word AND top-level enable word at 0x180), one cycle after that value changes.
- R8: An inbound write that matches no open group changes no pending bit and sets `capture_err`, which stays 1 until reset.
- R9: Readback: 0x180 returns the top-level enables, with only bits 15:8 and 27:24 writable. 0x190 returns the gates in bits 7:0. 0xC00 + 0x10·g returns the address low word, and 0xC80 + 4·g returns the high word. Unmapped addresses read 0.
- R10: `rd_data` carries the value addressed by `rd_addr` in the cycle after `rd_en` is 1. It is 0 in the cycle after a cycle without `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register write byte offset |
| reg_wdata | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 12 | Register read byte offset |
| rd_data | output | 32 | Registered read data |
| in_valid | input | 1 | Inbound MSI write valid |
| in_addr | input | 64 | Inbound write address |
| in_data | input | 32 | Inbound write data (low bits select the vector) |
| intx_msg_valid | input | 1 | INTx message valid |
| intx_msg_idx | input | 2 | INTx line index (0 = A … 3 = D) |
| intx_msg_assert | input | 1 | 1 = assert message, 0 = deassert message |
| irq | output | 1 | Registered interrupt to the CPU |
| capture_err | output | 1 | Sticky flag for an unmatched inbound write |

## Verification
A table of captures covers several groups, both ends of the vector range and a data word with junk in its upper bits. It also includes a repeated capture and a group whose address differs only in the high word. Together these separate a wrong address compare, a wrong index slice and a wrong group selection. Directed cases then check the following:
- a gated-off group and a high-word mismatch, which must both be dropped with the error flag raised;
- a per-vector enable that hides one pending bit from the summary;
- a clear and a capture on the same bit in the same cycle;
- write-zero immunity;
- an INTx clear attempted before and after the deassert message.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned REG_AW       = 12;
  localparam int unsigned OFS_TOP_EN   = 'h180;
  localparam int unsigned OFS_TOP_STAT = 'h184;
  localparam int unsigned OFS_GATE     = 'h190;
  localparam int unsigned OFS_SET_BASE = 'hC00;
  localparam int unsigned SET_STRIDE   = 'h10;
  localparam int unsigned OFS_PEND     = 'h4;
  localparam int unsigned OFS_VEN      = 'h8;
  localparam int unsigned OFS_HI_BASE  = 'hC80;
  localparam int unsigned HI_STRIDE    = 'h4;
  localparam int unsigned SET_LSB      = 8;
  localparam int unsigned INTX_LSB     = 24;
endpackage

// File: rtl/irq_msi_set.sv
module irq_msi_set import irq_pkg::*; #(
  parameter int unsigned VECS   = 32,
  parameter int unsigned SET_ID = 0,
  localparam int unsigned IDXW  = $clog2(VECS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              in_valid,
  input  logic [63:0]       in_addr,
  input  logic [IDXW-1:0]   in_idx,
  input  logic              gate,
  output logic              hit,
  output logic [31:0]       addr_lo,
  output logic [31:0]       addr_hi,
  output logic [VECS-1:0]   pend,
  output logic [VECS-1:0]   ven,
  output logic              summ
);
  localparam logic [REG_AW-1:0] LO_OFS  = REG_AW'(OFS_SET_BASE + SET_ID * SET_STRIDE);
  localparam logic [REG_AW-1:0] PND_OFS = REG_AW'(OFS_SET_BASE + SET_ID * SET_STRIDE + OFS_PEND);
  localparam logic [REG_AW-1:0] VEN_OFS = REG_AW'(OFS_SET_BASE + SET_ID * SET_STRIDE + OFS_VEN);
  localparam logic [REG_AW-1:0] HI_OFS  = REG_AW'(OFS_HI_BASE + SET_ID * HI_STRIDE);

  logic [VECS-1:0] pend_n;
  logic            clr_wr;

  always_comb begin
    hit    = in_valid && gate && (in_addr == {addr_hi, addr_lo});
    clr_wr = reg_we && (reg_addr == PND_OFS);
    for (int v = 0; v < VECS; v++) begin
      // a capture on the same bit overrides a same-cycle clear
      pend_n[v] = (hit && (in_idx == IDXW'(v))) ||
                  (pend[v] && !(clr_wr && reg_wdata[v]));
    end
    summ = |(pend & ven);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_lo <= '0;
      addr_hi <= '0;
      ven     <= '0;
      pend    <= '0;
    end else begin
      if (reg_we && reg_addr == LO_OFS)  addr_lo <= reg_wdata;
      if (reg_we && reg_addr == HI_OFS)  addr_hi <= reg_wdata;
      if (reg_we && reg_addr == VEN_OFS) ven     <= reg_wdata[VECS-1:0];
      pend <= pend_n;
    end
  end
endmodule

// File: rtl/irq_intx_track.sv
module irq_intx_track #(
  parameter int unsigned NUM_INTX = 4,
  localparam int unsigned IW      = $clog2(NUM_INTX)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                msg_valid,
  input  logic [IW-1:0]       msg_idx,
  input  logic                msg_assert,
  input  logic [NUM_INTX-1:0] clr_mask,
  output logic [NUM_INTX-1:0] line,
  output logic [NUM_INTX-1:0] stat
);
  logic [NUM_INTX-1:0] line_n;
  logic [NUM_INTX-1:0] stat_n;

  always_comb begin
    for (int n = 0; n < NUM_INTX; n++) begin
      line_n[n] = (msg_valid && msg_idx == IW'(n)) ? msg_assert : line[n];
      // a clear only takes effect once the line has been released
      stat_n[n] = line_n[n] || (stat[n] && !(clr_mask[n] && !line[n]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line <= '0;
      stat <= '0;
    end else begin
      line <= line_n;
      stat <= stat_n;
    end
  end
endmodule

// File: rtl/irq_rollup.sv
module irq_rollup import irq_pkg::*; #(
  parameter int unsigned NUM_SETS = 8,
  parameter int unsigned NUM_INTX = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_SETS-1:0] set_summ,
  input  logic [NUM_INTX-1:0] intx_stat,
  input  logic [31:0]         top_en,
  output logic [31:0]         top_stat,
  output logic                irq
);
  always_comb begin
    top_stat = '0;
    top_stat[SET_LSB +: NUM_SETS]  = set_summ;
    top_stat[INTX_LSB +: NUM_INTX] = intx_stat;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(top_stat & top_en);
  end
endmodule

// File: rtl/irq_collector.sv
module irq_collector import irq_pkg::*; #(
  parameter int unsigned NUM_SETS = 8,
  parameter int unsigned VECS     = 32,
  parameter int unsigned NUM_INTX = 4,
  localparam int unsigned IDXW    = $clog2(VECS),
  localparam int unsigned IW      = $clog2(NUM_INTX)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic              in_valid,
  input  logic [63:0]       in_addr,
  input  logic [31:0]       in_data,
  input  logic              intx_msg_valid,
  input  logic [IW-1:0]     intx_msg_idx,
  input  logic              intx_msg_assert,
  output logic              irq,
  output logic              capture_err
);
  localparam logic [31:0] SET_FIELD  = ((32'd1 << NUM_SETS) - 32'd1) << SET_LSB;
  localparam logic [31:0] INTX_FIELD = ((32'd1 << NUM_INTX) - 32'd1) << INTX_LSB;
  localparam logic [31:0] TOP_EN_MASK = SET_FIELD | INTX_FIELD;

  logic [31:0]         top_en;
  logic [NUM_SETS-1:0] gate;
  logic [NUM_SETS-1:0] hit;
  logic [NUM_SETS-1:0] set_summ;
  logic [31:0]         lo_a [NUM_SETS];
  logic [31:0]         hi_a [NUM_SETS];
  logic [VECS-1:0]     pend_a [NUM_SETS];
  logic [VECS-1:0]     ven_a [NUM_SETS];
  logic [NUM_INTX-1:0] intx_line;
  logic [NUM_INTX-1:0] intx_stat;
  logic [NUM_INTX-1:0] intx_clr;
  logic [31:0]         top_stat;
  logic [31:0]         rd_nxt;
  logic                unused_in_data_hi;

  assign unused_in_data_hi = ^in_data[31:IDXW];

  for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
    irq_msi_set #(.VECS(VECS), .SET_ID(g)) u_set (
      .clk(clk), .rst(rst),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .in_valid(in_valid), .in_addr(in_addr), .in_idx(in_data[IDXW-1:0]),
      .gate(gate[g]), .hit(hit[g]),
      .addr_lo(lo_a[g]), .addr_hi(hi_a[g]),
      .pend(pend_a[g]), .ven(ven_a[g]), .summ(set_summ[g])
    );
  end

  assign intx_clr = (reg_we && reg_addr == REG_AW'(OFS_TOP_STAT)) ?
                    reg_wdata[INTX_LSB +: NUM_INTX] : '0;

  irq_intx_track #(.NUM_INTX(NUM_INTX)) u_intx (
    .clk(clk), .rst(rst),
    .msg_valid(intx_msg_valid), .msg_idx(intx_msg_idx),
    .msg_assert(intx_msg_assert), .clr_mask(intx_clr),
    .line(intx_line), .stat(intx_stat)
  );

  irq_rollup #(.NUM_SETS(NUM_SETS), .NUM_INTX(NUM_INTX)) u_roll (
    .clk(clk), .rst(rst),
    .set_summ(set_summ), .intx_stat(intx_stat), .top_en(top_en),
    .top_stat(top_stat), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      top_en      <= '0;
      gate        <= '0;
      capture_err <= 1'b0;
    end else begin
      if (reg_we && reg_addr == REG_AW'(OFS_TOP_EN)) top_en <= reg_wdata & TOP_EN_MASK;
      if (reg_we && reg_addr == REG_AW'(OFS_GATE))   gate   <= reg_wdata[NUM_SETS-1:0];
      if (in_valid && !(|hit)) capture_err <= 1'b1;
    end
  end

  always_comb begin
    rd_nxt = '0;
    if (rd_addr == REG_AW'(OFS_TOP_EN))   rd_nxt = top_en;
    if (rd_addr == REG_AW'(OFS_TOP_STAT)) rd_nxt = top_stat;
    if (rd_addr == REG_AW'(OFS_GATE))     rd_nxt = 32'(gate);
    for (int g = 0; g < NUM_SETS; g++) begin
      if (rd_addr == REG_AW'(OFS_SET_BASE + g * SET_STRIDE))            rd_nxt = lo_a[g];
      if (rd_addr == REG_AW'(OFS_SET_BASE + g * SET_STRIDE + OFS_PEND)) rd_nxt = 32'(pend_a[g]);
      if (rd_addr == REG_AW'(OFS_SET_BASE + g * SET_STRIDE + OFS_VEN))  rd_nxt = 32'(ven_a[g]);
      if (rd_addr == REG_AW'(OFS_HI_BASE + g * HI_STRIDE))              rd_nxt = hi_a[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !rd_en) rd_data <= '0;
    else               rd_data <= rd_nxt;
  end
endmodule

// File: rtl/irq_collector_chk.sv
module irq_collector_chk #(
  parameter int unsigned NUM_INTX = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                rd_en,
  input logic [31:0]         rd_data,
  input logic                irq,
  input logic                capture_err,
  input logic [31:0]         top_stat,
  input logic [31:0]         top_en,
  input logic [NUM_INTX-1:0] intx_line,
  input logic [NUM_INTX-1:0] intx_stat
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!irq && !capture_err));

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
    capture_err |=> capture_err);

  a_r8_err_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(capture_err) |-> $past(in_valid));

  a_r6_line_holds_stat: assert property (@(posedge clk) disable iff (rst)
    !(|(intx_line & ~intx_stat)));

  a_r7_irq_needs_en: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|top_en));

  a_r7_no_src_no_irq: assert property (@(posedge clk) disable iff (rst)
    !(|top_stat) |=> !irq);

  a_r10_rd_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rd_data == 32'd0));
endmodule

bind irq_collector irq_collector_chk #(.NUM_INTX(NUM_INTX)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .rd_en(rd_en), .rd_data(rd_data),
  .irq(irq), .capture_err(capture_err), .top_stat(top_stat), .top_en(top_en),
  .intx_line(intx_line), .intx_stat(intx_stat)
);

// File: tb/irq_collector_tb.sv
`timescale 1ns/1ps
module irq_collector_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        rd_en = 1'b0;
  logic [11:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic        in_valid = 1'b0;
  logic [63:0] in_addr = '0;
  logic [31:0] in_data = '0;
  logic        intx_msg_valid = 1'b0;
  logic [1:0]  intx_msg_idx = '0;
  logic        intx_msg_assert = 1'b0;
  logic        irq;
  logic        capture_err;

  int total = 0;
  int bad = 0;
  logic [31:0] exp_pend [8];
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  irq_collector u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .in_valid(in_valid), .in_addr(in_addr), .in_data(in_data),
    .intx_msg_valid(intx_msg_valid), .intx_msg_idx(intx_msg_idx),
    .intx_msg_assert(intx_msg_assert), .irq(irq), .capture_err(capture_err)
  );

  // capture table: target group and inbound data word
  localparam int NT = 7;
  localparam logic [2:0]  TSET [NT] = '{3'd0, 3'd0, 3'd3, 3'd5, 3'd6, 3'd3, 3'd2};
  localparam logic [31:0] TDAT [NT] = '{32'h0, 32'h1F, 32'h11, 32'h4, 32'h9,
                                        32'hABCDE0F1, 32'hFFFFFFE7};

  function automatic logic [31:0] lo_of(input int s);
    return 32'h4000_0C00 + 32'(s) * 32'h10;
  endfunction
  function automatic logic [31:0] hi_of(input int s);
    return (s == 5) ? 32'h1 : 32'h0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(posedge clk);
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic cap(input logic [63:0] a, input logic [31:0] d);
    @(negedge clk); in_valid = 1'b1; in_addr = a; in_data = d;
    @(posedge clk);
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic intx(input logic [1:0] n, input logic asrt);
    @(negedge clk); intx_msg_valid = 1'b1; intx_msg_idx = n; intx_msg_assert = asrt;
    @(posedge clk);
    @(negedge clk); intx_msg_valid = 1'b0;
  endtask

  task automatic settle();
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int s = 0; s < 8; s++) exp_pend[s] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 irq in reset", 32'(irq), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 err after reset", 32'(capture_err), 32'd0);
    rd(12'hC04, rv); chk("R1 pending reset", rv, 32'd0);
    rd(12'h180, rv); chk("R1 top enable reset", rv, 32'd0);
    rd(12'h190, rv); chk("R1 gate reset", rv, 32'd0);

    for (int s = 0; s < 8; s++) begin
      wr(12'(32'hC00 + s * 16), lo_of(s));
      wr(12'(32'hC80 + s * 4), hi_of(s));
      wr(12'(32'hC08 + s * 16), 32'hFFFF_FFFF);
    end
    wr(12'h190, 32'h7F);
    rd(12'hC30, rv); chk("R9 addr low readback", rv, lo_of(3));
    rd(12'hC94, rv); chk("R9 addr high readback", rv, 32'h1);
    rd(12'h190, rv); chk("R9 gate readback", rv, 32'h7F);
    rd(12'h100, rv); chk("R9 unmapped read", rv, 32'd0);
    wr(12'h180, 32'hFFFF_FFFF);
    rd(12'h180, rv); chk("R9 top enable mask", rv, 32'h0F00_FF00);
    wr(12'h180, 32'h0);

    // R2: table-driven captures
    for (int i = 0; i < NT; i++) begin
      int s;
      s = int'(TSET[i]);
      cap({hi_of(s), lo_of(s)}, TDAT[i]);
      exp_pend[s] = exp_pend[s] | (32'd1 << TDAT[i][4:0]);
      rd(12'(32'hC04 + s * 16), rv);
      chk("R2 capture table", rv, exp_pend[s]);
    end
    chk("R8 no error on valid captures", 32'(capture_err), 32'd0);

    // R8: gated-off group, then high-word mismatch
    cap({hi_of(7), lo_of(7)}, 32'd3);
    rd(12'hC74, rv); chk("R8 gated group untouched", rv, 32'd0);
    chk("R8 error raised", 32'(capture_err), 32'd1);
    cap({32'h0, lo_of(5)}, 32'd6);
    rd(12'hC54, rv); chk("R8 high word mismatch dropped", rv, exp_pend[5]);
    settle();
    chk("R8 error sticky", 32'(capture_err), 32'd1);

    // R5: summary bits and per-vector enable
    rd(12'h184, rv); chk("R5 summary", rv, 32'h0000_6D00);
    wr(12'hC68, 32'hFFFF_FDFF);
    rd(12'h184, rv); chk("R5 vector enable hides", rv, 32'h0000_2D00);

    // R7: interrupt output
    settle();
    chk("R7 irq off without enable", 32'(irq), 32'd0);
    wr(12'h180, 32'h0000_0800);
    settle();
    chk("R7 irq on enabled group", 32'(irq), 32'd1);
    wr(12'hC34, 32'hFFFF_FFFF);
    settle();
    chk("R7 irq drops after clear", 32'(irq), 32'd0);
    rd(12'hC34, rv); chk("R3 clear all", rv, 32'd0);

    // R4 + R3: simultaneous clear and capture on group 0
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 12'hC04; reg_wdata = 32'h8000_0001;
    in_valid = 1'b1; in_addr = {hi_of(0), lo_of(0)}; in_data = 32'd0;
    @(posedge clk);
    @(negedge clk); reg_we = 1'b0; in_valid = 1'b0;
    rd(12'hC04, rv); chk("R4 capture beats clear", rv, 32'h0000_0001);
    wr(12'hC54, 32'h0);
    rd(12'hC54, rv); chk("R3 zero write keeps", rv, exp_pend[5]);

    // R6: INTx level behaviour on line C
    wr(12'h180, 32'h0);
    intx(2'd2, 1'b1);
    rd(12'h184, rv); chk("R6 assert sets status", rv & 32'h0F00_0000, 32'h0400_0000);
    wr(12'h184, 32'h0400_0000);
    rd(12'h184, rv); chk("R6 clear while asserted", rv & 32'h0F00_0000, 32'h0400_0000);
    wr(12'h180, 32'h0400_0000);
    settle();
    chk("R7 irq from INTx", 32'(irq), 32'd1);
    intx(2'd2, 1'b0);
    rd(12'h184, rv); chk("R6 holds after deassert", rv & 32'h0F00_0000, 32'h0400_0000);
    wr(12'h184, 32'h0400_0000);
    rd(12'h184, rv); chk("R6 cleared after deassert", rv & 32'h0F00_0000, 32'h0);
    settle();
    chk("R7 irq off after INTx clear", 32'(irq), 32'd0);

    // R10: read data returns to 0 when idle
    rd(12'h190, rv);
    settle();
    chk("R10 idle read data", rd_data, 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule